// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs raw NAND flash transactions on behalf of a host. The host picks one of four whole-page-level operations with a 3-bit code and presents it with a valid pulse while the block reports itself idle. The sequencer then drives the device's shared 8-bit bus. It issues command bytes with the command latch raised and address bytes with the address latch raised. Write data goes out on the write strobe and read data comes back on the read strobe. The block releases the bus whenever it is not driving it.

Every bus cycle is a fixed frame: one cycle of setup, a strobe pulse of a configurable width, then one cycle of hold. No frame begins while the device's ready line is low. After a confirm command the block lets a minimum number of cycles pass, then waits for ready to rise. Program data arrives from the host one byte at a time on a valid/ready port. Read data is returned on a valid/ready port, and no further read strobe is issued until the host has taken the byte on offer.

Top module: `nand_seq`

## Requirements
- R1: After reset, chip enable is high, both latch enables are low, both strobes are high, the bus is released (`nf_dq_hiz`=1), `op_ready`=1, and `op_done`, `rd_valid` are 0.
- R2: An operation code with bit 2 set (100 to 111) is ignored: no bus activity, chip enable stays high, `op_ready` stays 1 and no `op_done` follows.
- R3: Code 000 (reset) issues one command cycle with byte FFh, waits out the busy period, and then completes.
- R4: Code 001 (read ID) issues command 90h and one address cycle with byte 00h, then returns ID_BYTES bytes to the host in the order the device supplied them.
- R5: Code 010 (page read) issues command 00h, ADDR_BYTES address cycles taken from `op_addr` least significant byte first, and command 30h. It waits out the busy period, then returns PAGE_BYTES bytes in device order.
- R6: Code 011 (page program) issues command 80h, ADDR_BYTES address cycles (least significant byte first) and PAGE_BYTES data cycles carrying the host bytes in order, then command 10h, and waits out the busy period.
- R7: The command latch is high only on command cycles and the address latch only on address cycles, never both together. Latches and bus byte are held steady from one cycle before a strobe falls until one cycle after it rises.
- R8: Each strobe (`nf_we_n` for output cycles, `nf_re_n` for input cycles, both active low) is low for exactly STROBE_CYC consecutive cycles, and the two are never low together.
- R9: The bus is driven (`nf_dq_hiz`=0) during every output cycle and released during every read strobe and while idle.
- R10: A strobe falls only if `nf_rb` was high two cycles earlier, when that bus cycle was launched. While `nf_rb` is low no new bus cycle starts and no program byte is accepted.
- R11: After a confirm command (FFh, 30h, 10h) the block waits at least BUSY_MIN cycles and then until `nf_rb` is high. With `nf_rb` always high, `op_done` follows the cycle the write strobe rises by exactly BUSY_MIN+2 cycles. When the device is busy for L cycles, counted from that rise, the gap is exactly L+1 cycles (L > BUSY_MIN).
- R12: A returned byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen, and no read strobe falls while a byte is pending.
- R13: Chip enable is low for the whole operation, from the cycle after acceptance up to completion. `op_done` is a one-cycle pulse with chip enable already high, and `op_ready` returns the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Host requests an operation |
| op_code | input | 3 | Operation select (000 reset, 001 read ID, 010 page read, 011 page program) |
| op_addr | input | ADDR_BYTES*8 | Page/column address, least significant byte sent first |
| op_ready | output | 1 | Sequencer idle, will accept an operation |
| op_done | output | 1 | One-cycle completion pulse |
| wr_data | input | 8 | Program byte from host |
| wr_valid | input | 1 | Program byte present |
| wr_ready | output | 1 | Program byte taken this cycle when valid |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | Read byte pending |
| rd_ready | input | 1 | Host takes the pending read byte |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven onto the shared bus |
| nf_dq_hiz | output | 1 | High when the bus is released |
| nf_dq_in | input | 8 | Byte sampled from the shared bus |
| nf_rb | input | 1 | Device ready (high) / busy (low) |

## Verification
The two events that can meet in one cycle are the device's ready line dropping and the sequencer's wish to launch the next bus cycle. The sharpest case is during programming, with the sequencer idle between data cycles. The bench raises `wr_valid` and pulls `nf_rb` low in the very same cycle, so a new program byte is offered just as the device turns busy. It then requires that no write strobe falls and that `wr_ready` stays low for several cycles. After ready returns, the byte must go out exactly once, in its place in the page. A similar meeting on the read side is checked by holding `rd_ready` low while a byte is pending: the read strobe must stay quiet and the byte must stay stable.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_WDATA,
        ST_CMD2,
        ST_BUSY,
        ST_RDATA,
        ST_FINISH
    } seq_state_e;

    // low two bits of the operation code once bit 2 is known clear
    typedef enum logic [1:0] {
        OPK_RESET = 2'd0,
        OPK_RDID  = 2'd1,
        OPK_RDPG  = 2'd2,
        OPK_PROG  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } strobe_ph_e;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_ID      = 8'h90;
    localparam logic [7:0] CMD_RD_OPEN = 8'h00;
    localparam logic [7:0] CMD_RD_GO   = 8'h30;
    localparam logic [7:0] CMD_PG_OPEN = 8'h80;
    localparam logic [7:0] CMD_PG_GO   = 8'h10;

    function automatic logic [7:0] lead_cmd(op_kind_e k);
        case (k)
            OPK_RESET: lead_cmd = CMD_RESET;
            OPK_RDID:  lead_cmd = CMD_ID;
            OPK_RDPG:  lead_cmd = CMD_RD_OPEN;
            default:   lead_cmd = CMD_PG_OPEN;
        endcase
    endfunction

    function automatic logic [7:0] trail_cmd(op_kind_e k);
        trail_cmd = (k == OPK_PROG) ? CMD_PG_GO : CMD_RD_GO;
    endfunction

endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_seq_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_read,
    input  logic [7:0] dq_in,
    output logic       we_n,
    output logic       re_n,
    output logic       done,
    output logic [7:0] rd_byte
);
    localparam int CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

    typedef struct packed {
        strobe_ph_e       ph;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        logic [7:0]       byte_v;
    } stb_t;

    localparam stb_t RST_VAL = '{ph: PH_IDLE, cnt: '0, rd: 1'b0, byte_v: 8'h00};

    stb_t d, q;

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph  = PH_SETUP;
                    d.rd  = is_read;
                    d.cnt = '0;
                end
            end
            PH_SETUP: begin
                d.ph  = PH_PULSE;
                d.cnt = '0;
            end
            PH_PULSE: begin
                if (q.cnt == LAST) begin
                    d.ph = PH_HOLD;
                    if (q.rd) d.byte_v = dq_in;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign we_n    = !(q.ph == PH_PULSE && !q.rd);
    assign re_n    = !(q.ph == PH_PULSE &&  q.rd);
    assign done    = (q.ph == PH_HOLD);
    assign rd_byte = q.byte_v;

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int BUSY_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rb,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_MIN + 2);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.cnt    = CNT_W'(BUSY_MIN);
        end else if (q.active) begin
            if (q.cnt != '0)  d.cnt    = q.cnt - 1'b1;
            else if (rb)      d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{active: 1'b0, cnt: '0};
        else        q <= d;
    end

    assign done = q.active && (q.cnt == '0) && rb;

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 5,
    parameter int PAGE_BYTES = 8,
    parameter int ID_BYTES   = 4,
    parameter int STROBE_CYC = 2,
    parameter int BUSY_MIN   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [2:0]            op_code,
    input  logic [ADDR_BYTES*8-1:0] op_addr,
    output logic                  op_ready,
    output logic                  op_done,
    input  logic [7:0]            wr_data,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic                  nf_ce_n,
    output logic                  nf_cle,
    output logic                  nf_ale,
    output logic                  nf_we_n,
    output logic                  nf_re_n,
    output logic [7:0]            nf_dq_out,
    output logic                  nf_dq_hiz,
    input  logic [7:0]            nf_dq_in,
    input  logic                  nf_rb
);
    localparam int AW    = ADDR_BYTES * 8;
    localparam int CNT_W = $clog2(PAGE_BYTES + ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] PAGE_N    = CNT_W'(PAGE_BYTES);
    localparam logic [CNT_W-1:0] ID_N      = CNT_W'(ID_BYTES);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        seq_state_e       state;
        op_kind_e         kind;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic             in_cyc;
        logic             ce_n;
        logic             cle;
        logic             ale;
        logic             hiz;
        logic [7:0]       dq;
        logic             rd_valid;
        logic [7:0]       rd_data;
    } seq_t;

    localparam seq_t RST_VAL = '{
        state: ST_IDLE, kind: OPK_RESET, addr: '0, cnt: '0, in_cyc: 1'b0,
        ce_n: 1'b1, cle: 1'b0, ale: 1'b0, hiz: 1'b1, dq: 8'h00,
        rd_valid: 1'b0, rd_data: 8'h00
    };

    seq_t d, q;

    logic       cyc_start, cyc_read, stb_done;
    logic [7:0] stb_byte;
    logic       wt_start, wt_done;
    logic       take_wr;
    logic [CNT_W-1:0] addr_last, rd_total;

    assign addr_last = (q.kind == OPK_RDID) ? '0 : ADDR_LAST;
    assign rd_total  = (q.kind == OPK_RDID) ? ID_N : PAGE_N;

    always_comb begin
        d         = q;
        cyc_start = 1'b0;
        cyc_read  = 1'b0;
        wt_start  = 1'b0;
        take_wr   = 1'b0;

        if (q.rd_valid && rd_ready) d.rd_valid = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (op_valid && !op_code[2]) begin
                    d.kind  = op_kind_e'(op_code[1:0]);
                    d.addr  = (op_code[1:0] == OPK_RDID) ? '0 : op_addr;
                    d.cnt   = '0;
                    d.ce_n  = 1'b0;
                    d.state = ST_CMD1;
                end
            end

            ST_CMD1, ST_CMD2: begin
                if (!q.in_cyc) begin
                    if (nf_rb) begin
                        cyc_start = 1'b1;
                        d.in_cyc  = 1'b1;
                        d.cle     = 1'b1;
                        d.hiz     = 1'b0;
                        d.dq      = (q.state == ST_CMD1) ? lead_cmd(q.kind)
                                                         : trail_cmd(q.kind);
                    end
                end else if (stb_done) begin
                    d.in_cyc = 1'b0;
                    d.cle    = 1'b0;
                    d.hiz    = 1'b1;
                    if (q.state == ST_CMD2 || q.kind == OPK_RESET) begin
                        d.state  = ST_BUSY;
                        wt_start = 1'b1;
                    end else begin
                        d.state = ST_ADDR;
                        d.cnt   = '0;
                    end
                end
            end

            ST_ADDR: begin
                if (!q.in_cyc) begin
                    if (nf_rb) begin
                        cyc_start = 1'b1;
                        d.in_cyc  = 1'b1;
                        d.ale     = 1'b1;
                        d.hiz     = 1'b0;
                        d.dq      = q.addr[7:0];
                    end
                end else if (stb_done) begin
                    d.in_cyc = 1'b0;
                    d.ale    = 1'b0;
                    d.hiz    = 1'b1;
                    d.addr   = q.addr >> 8;
                    d.cnt    = q.cnt + 1'b1;
                    if (q.cnt == addr_last) begin
                        d.cnt = '0;
                        case (q.kind)
                            OPK_RDID: d.state = ST_RDATA;
                            OPK_PROG: d.state = ST_WDATA;
                            default:  d.state = ST_CMD2;
                        endcase
                    end
                end
            end

            ST_WDATA: begin
                if (!q.in_cyc) begin
                    if (q.cnt == PAGE_N) begin
                        d.state = ST_CMD2;
                    end else if (nf_rb) begin
                        take_wr = 1'b1;
                        if (wr_valid) begin
                            cyc_start = 1'b1;
                            d.in_cyc  = 1'b1;
                            d.hiz     = 1'b0;
                            d.dq      = wr_data;
                        end
                    end
                end else if (stb_done) begin
                    d.in_cyc = 1'b0;
                    d.hiz    = 1'b1;
                    d.cnt    = q.cnt + 1'b1;
                end
            end

            ST_BUSY: begin
                if (wt_done) begin
                    if (q.kind == OPK_RDPG) begin
                        d.state = ST_RDATA;
                        d.cnt   = '0;
                    end else begin
                        d.state = ST_FINISH;
                        d.ce_n  = 1'b1;
                    end
                end
            end

            ST_RDATA: begin
                if (!q.in_cyc) begin
                    if (!q.rd_valid) begin
                        if (q.cnt == rd_total) begin
                            d.state = ST_FINISH;
                            d.ce_n  = 1'b1;
                        end else if (nf_rb) begin
                            cyc_start = 1'b1;
                            cyc_read  = 1'b1;
                            d.in_cyc  = 1'b1;
                        end
                    end
                end else if (stb_done) begin
                    d.in_cyc   = 1'b0;
                    d.rd_valid = 1'b1;
                    d.rd_data  = stb_byte;
                    d.cnt      = q.cnt + 1'b1;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    nand_strobe_gen #(.STROBE_CYC(STROBE_CYC)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .is_read (cyc_read),
        .dq_in   (nf_dq_in),
        .we_n    (nf_we_n),
        .re_n    (nf_re_n),
        .done    (stb_done),
        .rd_byte (stb_byte)
    );

    nand_busy_timer #(.BUSY_MIN(BUSY_MIN)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wt_start),
        .rb    (nf_rb),
        .done  (wt_done)
    );

    assign op_ready  = (q.state == ST_IDLE);
    assign op_done   = (q.state == ST_FINISH);
    assign wr_ready  = take_wr;
    assign rd_data   = q.rd_data;
    assign rd_valid  = q.rd_valid;
    assign nf_ce_n   = q.ce_n;
    assign nf_cle    = q.cle;
    assign nf_ale    = q.ale;
    assign nf_dq_out = q.dq;
    assign nf_dq_hiz = q.hiz;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       op_ready,
    input logic       op_done,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_dq_out,
    input logic       nf_dq_hiz,
    input logic       nf_rb
);
    assert_latch_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    assert_latch_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || $rose(nf_we_n)) |->
            ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_out)));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    assert_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> !nf_dq_hiz);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> nf_dq_hiz);

    assert_ready_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nf_we_n) || $fell(nf_re_n)) |-> $past(nf_rb, 2));

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> nf_re_n);

    assert_ce_active_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (nf_ce_n && !op_ready) ##1 (op_ready && !op_done));

    assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code[2]) |=> (op_ready && nf_ce_n));

endmodule

bind nand_seq nand_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_ready  (op_ready),
    .op_done   (op_done),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_dq_out (nf_dq_out),
    .nf_dq_hiz (nf_dq_hiz),
    .nf_rb     (nf_rb)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
    localparam int AB = 5;
    localparam int PB = 8;
    localparam int IB = 4;
    localparam int SC = 2;
    localparam int BM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = 3'b000;
    logic [AB*8-1:0] op_addr = '0;
    logic          op_ready, op_done;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic          nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_hiz;
    logic [7:0]    nf_dq_out;
    logic [7:0]    nf_dq_in = 8'h00;
    logic          nf_rb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int busy_cnt = 0;
    int busy_len = 0;
    bit force_low = 1'b0;
    int log_n = 0;
    logic [10:0] log_e [0:31];
    int rd_idx = 0;
    int conf_cyc = 0;
    int strobe_falls = 0;
    int we_low = 0, re_low = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign nf_rb = (busy_cnt == 0) && !force_low;

    nand_seq #(.ADDR_BYTES(AB), .PAGE_BYTES(PB), .ID_BYTES(IB),
               .STROBE_CYC(SC), .BUSY_MIN(BM)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_ready(op_ready), .op_done(op_done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_hiz(nf_dq_hiz), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
    );

    function automatic logic [7:0] rd_pat(int k);
        return 8'h3C ^ 8'(k * 17);
    endfunction

    function automatic logic [7:0] wr_pat(int k);
        return 8'hC3 + 8'(k * 29);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // device model: logs output cycles, supplies read bytes, models busy time
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !nf_we_n) strobe_falls++;
            if (prev_re && !nf_re_n) strobe_falls++;
            if (!prev_we && nf_we_n) begin
                chk(we_low == SC, "R8 write strobe width", we_low, SC);
                chk(!nf_ce_n, "R13 chip enable during write cycle", nf_ce_n, 0);
                if (log_n < 32) log_e[log_n] = {nf_cle, nf_ale, nf_dq_hiz, nf_dq_out};
                log_n++;
                if (nf_cle && (nf_dq_out == 8'hFF || nf_dq_out == 8'h30 || nf_dq_out == 8'h10)) begin
                    busy_cnt = busy_len;
                    conf_cyc = cyc;
                end else if (busy_cnt > 0) busy_cnt--;
                if (nf_cle && (nf_dq_out == 8'h00 || nf_dq_out == 8'h90)) rd_idx = 0;
            end else if (busy_cnt > 0) busy_cnt--;
            if (!prev_re && nf_re_n) begin
                chk(re_low == SC, "R8 read strobe width", re_low, SC);
                rd_idx++;
            end
            if (!nf_re_n) begin
                chk(nf_dq_hiz, "R9 bus released during read strobe", nf_dq_hiz, 1);
                nf_dq_in = rd_pat(rd_idx);
            end
            we_low = nf_we_n ? 0 : we_low + 1;
            re_low = nf_re_n ? 0 : re_low + 1;
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    task automatic issue(input logic [2:0] code, input logic [AB*8-1:0] addr);
        log_n = 0;
        @(posedge clk); #1;
        op_valid = 1'b1; op_code = code; op_addr = addr;
        @(posedge clk); #1;
        op_valid = 1'b0;
        @(negedge clk);
        chk(!nf_ce_n, "R13 chip enable low after accept", nf_ce_n, 0);
    endtask

    task automatic wait_done(output int at);
        int n = 0;
        at = -1;
        while (n < 3000) begin
            @(negedge clk);
            if (op_done) begin
                at = cyc;
                chk(nf_ce_n, "R13 chip enable high at done", nf_ce_n, 1);
                break;
            end
            n++;
        end
        chk(at >= 0, "R13 operation completes", at, 0);
    endtask

    task automatic send_byte(input logic [7:0] b);
        int n = 0;
        wr_data = b; wr_valid = 1'b1;
        do begin @(negedge clk); n++; end while (!wr_ready && n < 500);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic recv_byte(input int k, input int hold, input string tag);
        int n = 0;
        int f0;
        logic [7:0] d0;
        do begin @(negedge clk); n++; end while (!rd_valid && n < 500);
        chk(rd_valid, {tag, " byte arrives"}, rd_valid, 1);
        if (hold > 0) begin
            f0 = strobe_falls; d0 = rd_data;
            repeat (hold) @(negedge clk);
            chk(rd_valid && rd_data == d0 && strobe_falls == f0,
                "R12 byte held without next strobe", strobe_falls - f0, 0);
        end
        chk(rd_data == rd_pat(k), tag, rd_data, rd_pat(k));
        @(posedge clk); #1; rd_ready = 1'b1;
        @(posedge clk); #1; rd_ready = 1'b0;
    endtask

    task automatic chk_log(input int i, input bit cle, input bit ale, input logic [7:0] b, input string tag);
        chk(log_e[i] == {cle, ale, 1'b0, b}, tag, log_e[i], {cle, ale, 1'b0, b});
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk(nf_ce_n && !nf_cle && !nf_ale && nf_we_n && nf_re_n && nf_dq_hiz,
            "R1 bus pins idle", {nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_hiz}, 6'b100111);
        chk(op_ready && !op_done && !rd_valid, "R1 host side idle",
            {op_ready, op_done, rd_valid}, 3'b100);
    endtask

    task automatic t_reserved;
        int f0 = strobe_falls;
        bit bad = 1'b0;
        for (int c = 4; c < 8; c++) begin
            @(posedge clk); #1;
            op_valid = 1'b1; op_code = 3'(c);
            @(posedge clk); #1;
            op_valid = 1'b0;
            repeat (8) begin
                @(negedge clk);
                if (!nf_ce_n || !op_ready || op_done) bad = 1'b1;
            end
        end
        chk(!bad && strobe_falls == f0, "R2 reserved codes ignored", strobe_falls - f0, 0);
    endtask

    task automatic t_reset_op(input int blen);
        int at;
        busy_len = blen;
        issue(3'b000, '0);
        wait_done(at);
        chk(log_n == 1, "R3 one bus cycle", log_n, 1);
        chk_log(0, 1, 0, 8'hFF, "R3 reset command byte");
        if (blen == 0)
            chk(at - conf_cyc == BM + 2, "R11 minimum busy wait", at - conf_cyc, BM + 2);
        else
            chk(at - conf_cyc == blen + 1, "R11 waits for ready", at - conf_cyc, blen + 1);
    endtask

    task automatic t_read_id;
        int at;
        busy_len = 0;
        issue(3'b001, 40'hFFFF_FFFF_FF);
        for (int k = 0; k < IB; k++) recv_byte(k, 0, "R4 id byte");
        wait_done(at);
        chk(log_n == 2, "R4 output cycles", log_n, 2);
        chk_log(0, 1, 0, 8'h90, "R4 id command");
        chk_log(1, 0, 1, 8'h00, "R4 id address");
    endtask

    task automatic t_read_page;
        int at;
        logic [AB*8-1:0] a = 40'h12_3456_789A;
        busy_len = 9;
        issue(3'b010, a);
        for (int k = 0; k < PB; k++) recv_byte(k, (k == 2) ? 5 : 0, "R5 page byte");
        wait_done(at);
        chk(log_n == AB + 2, "R5 output cycles", log_n, AB + 2);
        chk_log(0, 1, 0, 8'h00, "R5 open command");
        for (int i = 0; i < AB; i++) chk_log(1 + i, 0, 1, a[8*i +: 8], "R5 address byte");
        chk_log(AB + 1, 1, 0, 8'h30, "R5 confirm command");
        chk(at - conf_cyc >= busy_len + 1, "R11 read waits for ready", at - conf_cyc, busy_len + 1);
    endtask

    task automatic t_program;
        int at;
        int f0;
        bit bad;
        logic [AB*8-1:0] a = 40'hA5_0102_0304;
        busy_len = 7;
        issue(3'b011, a);
        for (int k = 0; k < 3; k++) send_byte(wr_pat(k));
        repeat (10) @(negedge clk);
        // ready drops in the very cycle a new byte is offered
        @(posedge clk); #1;
        force_low = 1'b1; wr_data = wr_pat(3); wr_valid = 1'b1;
        f0 = strobe_falls; bad = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (!nf_we_n || wr_ready) bad = 1'b1;
        end
        chk(!bad && strobe_falls == f0, "R10 no cycle while busy", strobe_falls - f0, 0);
        @(posedge clk); #1; force_low = 1'b0;
        send_byte(wr_pat(3));
        for (int k = 4; k < PB; k++) send_byte(wr_pat(k));
        wait_done(at);
        chk(log_n == AB + PB + 2, "R6 output cycles", log_n, AB + PB + 2);
        chk_log(0, 1, 0, 8'h80, "R6 open command");
        for (int i = 0; i < AB; i++) chk_log(1 + i, 0, 1, a[8*i +: 8], "R6 address byte");
        for (int k = 0; k < PB; k++) chk_log(1 + AB + k, 0, 0, wr_pat(k), "R6 data byte");
        chk_log(AB + PB + 1, 1, 0, 8'h10, "R6 confirm command");
        chk(at - conf_cyc == busy_len + 1, "R11 program waits for ready", at - conf_cyc, busy_len + 1);
        @(negedge clk);
        chk(op_ready, "R13 ready after done", op_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_reserved();
        t_reset_op(0);
        t_reset_op(12);
        t_read_id();
        t_read_page();
        t_program();
        t_reserved();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule